// File: doc/BRIEF.md
# Inverted Page Translator with Associative Lookup

This block maps processor addresses onto physical DRAM pages through an inverted page table. The table has one associative cell for each physical page. Each cell holds the logical page number that the page currently answers to, together with a 2-bit protection code. A lookup compares the logical page of the incoming address against every cell at once. The index of the matching cell is the physical page. Because each physical page owns exactly one cell, a page can appear at only one logical address at a time. Pages that are not in use are parked together on a reserved logical page with no access allowed.

A fixed decode splits the 64 MB address space into four regions:
- the lower 32 MB, which is translated through the table;
- a 16 MB window of directly mapped RAM;
- an 8 MB block of other I/O space;
- an 8 MB ROM window.

Supervisor accesses are never refused. User accesses are refused in the direct RAM and I/O windows. In translated RAM, a user access is allowed only as far as the protection code of the page permits. The page size can be 4, 8, 16 or 32 KB, chosen through a control write. The width of the logical page field follows the chosen size. Each response is registered and appears one cycle after the access is presented.

Top module: `cam_xlat_mmu`

## Requirements
- R1: After reset, every cell holds the parking logical page (default 1023) with protection code 2'b00, the page size is 32 KB, and rsp_valid_o, hit_o, multi_o and abort_o are low.
- R2: A table write with tw_en_i high loads tw_lpn_i and tw_prot_i into exactly the cell selected by tw_idx_i, in one clock edge. From the next access on, the old logical page of that cell no longer maps to it.
- R3: An address with bit 25 clear is translated. Its logical page is acc_addr_i[24:12] shifted right by the page-size code. When exactly one cell matches, hit_o is 1 and ppn_o is the index of that cell.
- R4: ctl_we_i loads ctl_pgsz_i as the page-size code: 0 selects 4 KB, 1 selects 8 KB, 2 selects 16 KB and 3 selects 32 KB. The code applies to every later access.
- R5: When two or more cells match a translated access, multi_o is 1, hit_o is 0, and a user access aborts.
- R6: A translated access that matches no cell gives hit_o 0. It aborts in user mode and does not abort in supervisor mode.
- R7: Protection codes are 2'b00 for no access, 2'b01 for read-only and 2'b1x for read-write. A user read aborts only on code 2'b00. A user write aborts unless bit 1 of the code is set.
- R8: A supervisor access (acc_user_i low) never aborts, whatever the region or the protection code.
- R9: Addresses 0x2000000 to 0x2FFFFFF are directly mapped RAM. They give hit_o 1, with ppn_o equal to the low 7 bits of acc_addr_i[23:12] shifted right by the page-size code. User accesses there abort.
- R10: Addresses 0x3000000 to 0x37FFFFF are I/O space, where user accesses abort. Addresses 0x3800000 to 0x3FFFFFF are ROM, where user accesses are allowed. Both give hit_o 0.
- R11: region_o reports the decoded region: 0 for translated, 1 for direct, 2 for I/O and 3 for ROM.
- R12: rsp_valid_o is high exactly one cycle after an edge at which acc_valid_i was high. While rsp_valid_o is low, hit_o, multi_o and abort_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Loads the page-size code |
| ctl_pgsz_i | input | 2 | Page-size code |
| acc_valid_i | input | 1 | Access present |
| acc_addr_i | input | 26 | Access byte address |
| acc_write_i | input | 1 | 1 for a write access, 0 for a read |
| acc_user_i | input | 1 | 1 for a user-mode access, 0 for supervisor |
| tw_en_i | input | 1 | Table write strobe |
| tw_idx_i | input | 7 | Physical page (cell) to program |
| tw_lpn_i | input | 13 | Logical page number for the cell |
| tw_prot_i | input | 2 | Protection code for the cell |
| rsp_valid_o | output | 1 | Response valid |
| hit_o | output | 1 | ppn_o holds a valid physical page |
| multi_o | output | 1 | More than one cell matched |
| abort_o | output | 1 | Access refused |
| region_o | output | 2 | Decoded region |
| ppn_o | output | 7 | Physical page index |

## Verification
The bench targets these corner cases, and what a faulty design would do in each:

- **Parked pages after reset.** All 128 cells share one logical page, so an access to that page must come back as a multi-hit. A design that priority-encodes the matches would report a false hit on some page instead.
- **Remapping a cell.** After a cell is moved to a new logical page, its old logical address must miss. Stale match state would still translate the old address.
- **Protection at user level.** Read-only and no-access pages are accessed by user reads and writes, and also by supervisor accesses. This catches a swapped protection bit, and it catches an abort raised in supervisor mode.
- **Page size and windows.** The page size is changed to 4 KB and 8 KB, so that a field extracted at the wrong offset maps to the wrong page. The direct, I/O and ROM windows, including a direct page index that wraps, check the region boundaries and the rule that only ROM is open to user mode.

// File: rtl/cam_xlat_pkg.sv
package cam_xlat_pkg;
  typedef enum logic [1:0] {
    RG_XLAT   = 2'd0,
    RG_DIRECT = 2'd1,
    RG_IO     = 2'd2,
    RG_ROM    = 2'd3
  } region_e;

  localparam logic [1:0] PROT_NONE = 2'b00;
  localparam logic [1:0] PROT_RO   = 2'b01;
  localparam logic [1:0] PROT_RW   = 2'b10;
endpackage

// File: rtl/cam_table.sv
module cam_table #(
  parameter int NUM_PAGES = 128,
  parameter int LPN_W     = 13,
  parameter int IDX_W     = 7,
  parameter int PARK_LPN  = 1023
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [LPN_W-1:0]                wr_lpn_i,
  input  logic [1:0]                      wr_prot_i,
  input  logic [LPN_W-1:0]                query_i,
  output logic [NUM_PAGES-1:0]            match_o,
  output logic [NUM_PAGES-1:0][1:0]       prot_o
);
  import cam_xlat_pkg::*;

  logic [NUM_PAGES-1:0][LPN_W-1:0] lpn_q;
  logic [NUM_PAGES-1:0][1:0]       prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PAGES; i++) begin
        lpn_q[i]  <= LPN_W'(PARK_LPN);
        prot_q[i] <= PROT_NONE;
      end
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_PAGES; i++) begin
        if (wr_idx_i == IDX_W'(i)) begin
          lpn_q[i]  <= wr_lpn_i;
          prot_q[i] <= wr_prot_i;
        end
      end
    end
  end

  // one comparator per physical page
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_cell
    assign match_o[g] = (lpn_q[g] == query_i);
  end

  assign prot_o = prot_q;

  // R2: the written cell holds the new content one edge later
  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (lpn_q[$past(wr_idx_i)] == $past(wr_lpn_i)) &&
                (prot_q[$past(wr_idx_i)] == $past(wr_prot_i)));

  // R2: a cell that was not addressed keeps its content
  p_other_cell_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i != '0) |=> $stable(lpn_q[0]));
endmodule

// File: rtl/match_encode.sv
module match_encode #(
  parameter int NUM_PAGES = 128,
  parameter int IDX_W     = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PAGES-1:0] match_i,
  output logic                 any_o,
  output logic                 multi_o,
  output logic [IDX_W-1:0]     idx_o
);
  // OR of indices; only meaningful for a single match
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_PAGES; i++) begin
      if (match_i[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign any_o   = |match_i;
  assign multi_o = |(match_i & (match_i - NUM_PAGES'(1)));

  // R5: multi flag tracks a population of two or more
  p_multi_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o == ($countones(match_i) > 1));

  // R3: single match yields the matching index
  p_single_index_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_o && !multi_o) |-> match_i[idx_o]);
endmodule

// File: rtl/region_decode.sv
module region_decode #(
  parameter int ADDR_W = 26
) (
  input  logic [ADDR_W-1:0]      addr_i,
  output cam_xlat_pkg::region_e  region_o
);
  import cam_xlat_pkg::*;

  always_comb begin
    if (!addr_i[ADDR_W-1])      region_o = RG_XLAT;
    else if (!addr_i[ADDR_W-2]) region_o = RG_DIRECT;
    else if (!addr_i[ADDR_W-3]) region_o = RG_IO;
    else                        region_o = RG_ROM;
  end
endmodule

// File: rtl/cam_xlat_mmu.sv
module cam_xlat_mmu #(
  parameter int NUM_PAGES    = 128,
  parameter int ADDR_W       = 26,
  parameter int MIN_PG_SHIFT = 12,
  parameter int PARK_LPN     = 1023,
  localparam int IDX_W       = $clog2(NUM_PAGES),
  localparam int LPN_W       = ADDR_W - 1 - MIN_PG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [1:0]        ctl_pgsz_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              acc_user_i,
  input  logic              tw_en_i,
  input  logic [IDX_W-1:0]  tw_idx_i,
  input  logic [LPN_W-1:0]  tw_lpn_i,
  input  logic [1:0]        tw_prot_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic              multi_o,
  output logic              abort_o,
  output logic [1:0]        region_o,
  output logic [IDX_W-1:0]  ppn_o
);
  import cam_xlat_pkg::*;

  localparam int DPG_W = ADDR_W - 2 - MIN_PG_SHIFT;

  logic [1:0] pgsz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pgsz_q <= 2'd3;
    else if (ctl_we_i) pgsz_q <= ctl_pgsz_i;
  end

  // page fields, right-aligned for the selected size
  logic [LPN_W-1:0] query;
  logic [DPG_W-1:0] dpage;
  logic [MIN_PG_SHIFT-1:0] unused_offset;
  logic [DPG_W-IDX_W-1:0]  unused_dpage_hi;

  assign query           = acc_addr_i[ADDR_W-2:MIN_PG_SHIFT] >> pgsz_q;
  assign dpage           = acc_addr_i[ADDR_W-3:MIN_PG_SHIFT] >> pgsz_q;
  assign unused_offset   = acc_addr_i[MIN_PG_SHIFT-1:0];
  assign unused_dpage_hi = dpage[DPG_W-1:IDX_W];

  logic [NUM_PAGES-1:0]      match;
  logic [NUM_PAGES-1:0][1:0] cell_prot;
  logic                      any_m, multi_m;
  logic [IDX_W-1:0]          idx_m;
  region_e                   region_d;

  cam_table #(
    .NUM_PAGES (NUM_PAGES),
    .LPN_W     (LPN_W),
    .IDX_W     (IDX_W),
    .PARK_LPN  (PARK_LPN)
  ) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (tw_en_i),
    .wr_idx_i  (tw_idx_i),
    .wr_lpn_i  (tw_lpn_i),
    .wr_prot_i (tw_prot_i),
    .query_i   (query),
    .match_o   (match),
    .prot_o    (cell_prot)
  );

  match_encode #(
    .NUM_PAGES (NUM_PAGES),
    .IDX_W     (IDX_W)
  ) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (match),
    .any_o   (any_m),
    .multi_o (multi_m),
    .idx_o   (idx_m)
  );

  region_decode #(.ADDR_W(ADDR_W)) u_region (
    .addr_i   (acc_addr_i),
    .region_o (region_d)
  );

  logic             hit_d, multi_d, abort_d, single;
  logic [IDX_W-1:0] ppn_d;
  logic [1:0]       prot_sel;

  assign single   = any_m && !multi_m;
  assign prot_sel = cell_prot[idx_m];

  always_comb begin
    hit_d   = 1'b0;
    multi_d = 1'b0;
    abort_d = 1'b0;
    ppn_d   = '0;
    unique case (region_d)
      RG_XLAT: begin
        hit_d   = single;
        multi_d = multi_m;
        ppn_d   = single ? idx_m : '0;
        if (acc_user_i) begin
          if (!single)          abort_d = 1'b1;
          else if (acc_write_i) abort_d = !prot_sel[1];
          else                  abort_d = (prot_sel == PROT_NONE);
        end
      end
      RG_DIRECT: begin
        hit_d   = 1'b1;
        ppn_d   = dpage[IDX_W-1:0];
        abort_d = acc_user_i;
      end
      RG_IO:   abort_d = acc_user_i;
      default: abort_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      multi_o     <= 1'b0;
      abort_o     <= 1'b0;
      region_o    <= 2'd0;
      ppn_o       <= '0;
    end else begin
      rsp_valid_o <= acc_valid_i;
      hit_o       <= acc_valid_i && hit_d;
      multi_o     <= acc_valid_i && multi_d;
      abort_o     <= acc_valid_i && abort_d;
      region_o    <= acc_valid_i ? region_d : 2'd0;
      ppn_o       <= acc_valid_i ? ppn_d : '0;
    end
  end

  p_valid_latency_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> rsp_valid_o);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(hit_o || multi_o || abort_o));

  p_hit_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && multi_o));

  p_sup_never_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !$past(acc_user_i)) |-> !abort_o);

  p_user_miss_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && region_o == 2'd0 && !hit_o && $past(acc_user_i)) |-> abort_o);

  p_direct_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && region_o == 2'd1) |-> (hit_o && !multi_o));
endmodule

// File: tb/tb_cam_xlat_mmu.sv
module tb_cam_xlat_mmu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_pgsz = 2'd0;
  logic        acc_valid = 1'b0;
  logic [25:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_user = 1'b0;
  logic        tw_en = 1'b0;
  logic [6:0]  tw_idx = '0;
  logic [12:0] tw_lpn = '0;
  logic [1:0]  tw_prot = '0;
  logic        rsp_valid, hit, multi, abort_w;
  logic [1:0]  region;
  logic [6:0]  ppn;

  always #10 clk = ~clk;

  cam_xlat_mmu dut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_pgsz_i(ctl_pgsz),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_write_i(acc_write),
    .acc_user_i(acc_user), .tw_en_i(tw_en), .tw_idx_i(tw_idx), .tw_lpn_i(tw_lpn),
    .tw_prot_i(tw_prot), .rsp_valid_o(rsp_valid), .hit_o(hit), .multi_o(multi),
    .abort_o(abort_w), .region_o(region), .ppn_o(ppn)
  );

  typedef struct {
    logic       hit, multi, abt;
    logic [1:0] rg;
    logic [6:0] pp;
    string      tag;
  } exp_t;

  exp_t  sb[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  logic [12:0] m_lpn [128];
  logic [1:0]  m_prot [128];
  logic [1:0]  m_pgsz;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(logic [25:0] a, logic wr, logic usr, string tag);
    exp_t e;
    int cnt = 0, last = 0;
    logic [12:0] q;
    logic [11:0] d;
    e.tag = tag; e.hit = 0; e.multi = 0; e.abt = 0; e.pp = '0; e.rg = 2'd0;
    if (!a[25]) begin
      q = a[24:12] >> m_pgsz;
      for (int i = 0; i < 128; i++) if (m_lpn[i] == q) begin cnt++; last = i; end
      if (cnt == 1) begin
        e.hit = 1; e.pp = 7'(last);
        if (usr) e.abt = wr ? !m_prot[last][1] : (m_prot[last] == 2'b00);
      end else begin
        e.multi = (cnt > 1);
        e.abt = usr;
      end
    end else if (!a[24]) begin
      e.rg = 2'd1; e.hit = 1; d = a[23:12] >> m_pgsz; e.pp = d[6:0]; e.abt = usr;
    end else if (!a[23]) begin
      e.rg = 2'd2; e.abt = usr;
    end else begin
      e.rg = 2'd3;
    end
    return e;
  endfunction

  function automatic logic [25:0] la(int lpn);
    return 26'(lpn) << (12 + m_pgsz);
  endfunction

  task automatic access(logic [25:0] a, logic wr, logic usr, string tag);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_write = wr; acc_user = usr;
    sb.push_back(model(a, wr, usr, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic tw(int idx, int lpn, logic [1:0] p);
    @(negedge clk);
    acc_valid = 0; tw_en = 1; tw_idx = 7'(idx); tw_lpn = 13'(lpn); tw_prot = p;
    m_lpn[idx] = 13'(lpn); m_prot[idx] = p;
    @(negedge clk);
    tw_en = 0;
  endtask

  task automatic set_pgsz(logic [1:0] s);
    @(negedge clk);
    acc_valid = 0; ctl_we = 1; ctl_pgsz = s; m_pgsz = s;
    @(negedge clk);
    ctl_we = 0;
  endtask

  // monitor: compare each response against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R12", "unexpected rsp_valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(hit == e.hit && multi == e.multi && abort_w == e.abt && region == e.rg &&
            (!e.hit || ppn == e.pp), e.tag, "hit/multi/abort/region/ppn",
            {hit, multi, abort_w, region, ppn}, {e.hit, e.multi, e.abt, e.rg, e.pp});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin m_lpn[i] = 13'd1023; m_prot[i] = 2'b00; end
    m_pgsz = 2'd3;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: quiet outputs after reset
    chk(!rsp_valid && !hit && !multi && !abort_w, "R1", "reset outputs",
        {rsp_valid, hit, multi, abort_w}, 0);
    // R1 R5: all cells parked on the same page
    access(la(1023), 0, 0, "R1_park_sup");
    access(la(1023), 0, 1, "R5_park_user");
    // R2 R3 R7: read-write page
    tw(5, 2, 2'b10);
    access(la(2), 0, 1, "R3_user_read_rw");
    access(la(2), 1, 1, "R7_user_write_rw");
    // R7 R8: read-only page
    tw(9, 3, 2'b01);
    access(la(3), 0, 1, "R7_user_read_ro");
    access(la(3), 1, 1, "R7_user_write_ro");
    access(la(3), 1, 0, "R8_sup_write_ro");
    // R7 R8: no-access page; code 2'b11 acts as read-write
    tw(12, 4, 2'b00);
    tw(13, 5, 2'b11);
    access(la(4), 0, 1, "R7_user_read_none");
    access(la(4), 1, 0, "R8_sup_write_none");
    access(la(5), 1, 1, "R7_user_write_code3");
    // R6: unmapped page
    access(la(7), 0, 1, "R6_user_miss");
    access(la(7), 1, 0, "R6_sup_miss");
    // R2: moving a cell leaves its old address unmapped
    tw(5, 6, 2'b10);
    access(la(2), 0, 1, "R2_old_lpn_gone");
    access(la(6), 0, 1, "R2_new_lpn");
    // R5: two cells on one page
    tw(20, 6, 2'b10);
    access(la(6), 0, 1, "R5_dup_user");
    access(la(6), 0, 0, "R5_dup_sup");
    tw(20, 1023, 2'b00);
    // R4: smaller pages
    set_pgsz(2'd0);
    access(la(6), 0, 1, "R4_4k_hit");
    access(26'(6) << 15, 0, 1, "R4_4k_other_page");
    access(la(6) + 26'h0FFF, 1, 1, "R4_4k_last_byte");
    set_pgsz(2'd1);
    access(la(6), 0, 1, "R4_8k_hit");
    access(la(3), 0, 0, "R4_8k_sup");
    set_pgsz(2'd3);
    // R9: direct window
    access(26'h2000000 + la(5), 0, 0, "R9_direct_sup");
    access(26'h2000000 + la(5), 0, 1, "R9_direct_user");
    access(26'h2000000 + la(130), 1, 0, "R9_direct_wrap");
    // R10 R11: I/O and ROM
    access(26'h3000000, 0, 1, "R10_io_user");
    access(26'h37FFFFC, 0, 0, "R10_io_sup");
    access(26'h3800000, 0, 1, "R10_rom_user");
    access(26'h3FFFFFC, 0, 1, "R11_rom_top");
    access(26'h1FFFFFC, 0, 0, "R11_xlat_top");
    idle();
    @(negedge clk);
    // R12: nothing reported while idle
    chk(!rsp_valid && !hit && !abort_w, "R12", "idle outputs", {rsp_valid, hit, abort_w}, 0);
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R12", "pending responses", sb.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule